// File: doc/BRIEF.md
# Signature-Based Transactional Conflict Detector

This block keeps an approximate record of which cache lines one transaction has read and which it has written. Each footprint is a fixed-size bit vector. An address is reduced to its line number, hashed by two independent XOR-fold functions, and the two selected bits are set in the read vector or the write vector. The core inserts into the vectors from a valid/ready port, on every transactional load and store.

Accesses from other agents arrive on a second valid/ready port. Each one carries a line address and a read/write flag. It is tested at once against both vectors. If the kind of access crosses a footprint in a way that breaks isolation, the block raises a one-cycle abort pulse with a two-bit code for the kind of conflict. Because the vectors are hashed, some probes report a conflict that did not happen. A conflict that did happen is never missed. A clear input empties both vectors when the transaction commits or aborts.

Back-pressure rules: the insert port is ready only while a transaction is open. An insert is taken on a cycle in which both valid and ready are high and no clear is requested. The probe port never back-pressures, so its ready is held high. A probe has an effect only while a transaction is open.

Top module: `sig_conflict_det`

## Requirements
- R1: Only the line address (address bits 31 down to 6 at the default parameters) takes part. Two addresses in the same 64-byte line behave the same for both insert and probe.
- R2: Hash 0 is the XOR of the line address split into 8-bit chunks, where chunk 0 holds the least significant bits and the top chunk is zero-padded. Hash 1 is the same XOR with chunk i first rotated left by i mod 8. A signature hit requires both selected bits to be set.
- R3: A remote write whose line hits the read signature, and does not hit the write signature, raises kind 2'b01.
- R4: A remote read whose line hits the write signature raises kind 2'b10.
- R5: A remote write whose line hits the write signature raises kind 2'b11. This holds even when the line also hits the read signature.
- R6: A remote read that hits only the read signature raises no conflict.
- R7: abort_pulse goes high in the cycle after the clock edge that accepted the conflicting probe, and it stays high for that one cycle per probe. abort_kind is 2'b00 whenever abort_pulse is low.
- R8: When an insert and a probe occur in the same cycle, the probe is judged on the signatures as they stood before that insert.
- R9: Outside an open transaction, ins_ready is low, inserts are dropped and probes never raise a conflict.
- R10: tx_clear empties both signatures and closes the transaction. If tx_begin is also high, the transaction is open on the next cycle with empty signatures. An insert presented in a clear cycle is dropped.
- R11: Aliasing is permitted: a line never inserted still conflicts when both of its hashed bits were set by other lines.
- R12: After reset no transaction is open, both signatures are empty, abort_pulse is low and prb_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| tx_clear | input | 1 | Empty both signatures and close the transaction (commit or abort) |
| ins_valid | input | 1 | Local transactional access to record |
| ins_ready | output | 1 | High while a transaction is open |
| ins_addr | input | 32 | Byte address of the local access |
| ins_is_wr | input | 1 | 1 = store (write signature), 0 = load (read signature) |
| prb_valid | input | 1 | Remote access to test |
| prb_ready | output | 1 | Always high |
| prb_addr | input | 32 | Byte address of the remote access |
| prb_is_wr | input | 1 | 1 = remote write, 0 = remote read |
| abort_pulse | output | 1 | One-cycle conflict indication |
| abort_kind | output | 2 | 01 read-write, 10 write-read, 11 write-write, 00 none |

## Verification
A local insert and a remote probe of the same line can arrive in the same cycle. The bench presents both together: a load of a line with a remote write to that same line. It expects no pulse, since the probe must see the older signature. It then repeats the probe alone on the next cycle and expects kind 2'b01. This shows that the insert did land, and that the ordering within the shared cycle was what kept the first probe silent. A clear cycle that carries an insert is judged the same way, by probing that line afterwards.

// File: rtl/sigcd_pkg.sv
package sigcd_pkg;
  typedef enum logic [1:0] {
    CONF_NONE = 2'b00,
    CONF_RW   = 2'b01,
    CONF_WR   = 2'b10,
    CONF_WW   = 2'b11
  } conf_kind_e;
endpackage

// File: rtl/sigcd_hash.sv
module sigcd_hash #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int IDX_W    = 8,
  parameter int HASH_ID  = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam int NCH    = (LINE_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCH * IDX_W;

  logic [PAD_W-1:0] line_pad;
  logic [NCH-1:0][IDX_W-1:0] rot;
  logic unused_ofs;

  assign line_pad   = PAD_W'(addr[ADDR_W-1:LINE_OFS]);
  assign unused_ofs = ^addr[LINE_OFS-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    localparam int SH = (g * HASH_ID) % IDX_W;
    logic [IDX_W-1:0] chunk;
    assign chunk = line_pad[g*IDX_W +: IDX_W];
    if (SH == 0) begin : g_plain
      assign rot[g] = chunk;
    end else begin : g_rot
      assign rot[g] = {chunk[IDX_W-SH-1:0], chunk[IDX_W-1:IDX_W-SH]};
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) idx = idx ^ rot[i];
  end
endmodule

// File: rtl/sigcd_sig.sv
module sigcd_sig #(
  parameter int SIG_BITS = 256,
  parameter int NUM_HASH = 2,
  parameter int IDX_W    = $clog2(SIG_BITS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr,
  input  logic                               ins_en,
  input  logic [NUM_HASH-1:0][IDX_W-1:0]     ins_idx,
  input  logic [NUM_HASH-1:0][IDX_W-1:0]     tst_idx,
  output logic                               hit
);
  logic [SIG_BITS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bits_q <= '0;
    end else if (ins_en) begin
      for (int h = 0; h < NUM_HASH; h++) bits_q[ins_idx[h]] <= 1'b1;
    end
  end

  always_comb begin
    hit = 1'b1;
    for (int h = 0; h < NUM_HASH; h++) hit = hit & bits_q[tst_idx[h]];
  end
endmodule

// File: rtl/sigcd_classify.sv
module sigcd_classify
  import sigcd_pkg::*;
(
  input  logic       prb_en,
  input  logic       prb_is_wr,
  input  logic       rd_hit,
  input  logic       wr_hit,
  output conf_kind_e kind
);
  always_comb begin
    kind = CONF_NONE;
    if (prb_en) begin
      if (prb_is_wr && wr_hit)       kind = CONF_WW;
      else if (prb_is_wr && rd_hit)  kind = CONF_RW;
      else if (!prb_is_wr && wr_hit) kind = CONF_WR;
    end
  end
endmodule

// File: rtl/sig_conflict_det.sv
module sig_conflict_det
  import sigcd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int SIG_BITS = 256,
  parameter int NUM_HASH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_clear,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_is_wr,
  input  logic              prb_valid,
  output logic              prb_ready,
  input  logic [ADDR_W-1:0] prb_addr,
  input  logic              prb_is_wr,
  output logic              abort_pulse,
  output logic [1:0]        abort_kind
);
  localparam int IDX_W = $clog2(SIG_BITS);

  logic tx_active_q;
  logic ins_fire, prb_en, rd_hit, wr_hit;
  logic [NUM_HASH-1:0][IDX_W-1:0] ins_idx, prb_idx;
  conf_kind_e kind;

  always_ff @(posedge clk) begin
    if (!rst_n)                   tx_active_q <= 1'b0;
    else if (tx_clear || tx_begin) tx_active_q <= tx_begin;
  end

  assign ins_ready = tx_active_q;
  assign prb_ready = 1'b1;
  assign ins_fire  = ins_valid && tx_active_q && !tx_clear;
  assign prb_en    = prb_valid && tx_active_q;

  for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
    sigcd_hash #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .IDX_W(IDX_W), .HASH_ID(h))
      u_ins_hash (.addr(ins_addr), .idx(ins_idx[h]));
    sigcd_hash #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .IDX_W(IDX_W), .HASH_ID(h))
      u_prb_hash (.addr(prb_addr), .idx(prb_idx[h]));
  end

  sigcd_sig #(.SIG_BITS(SIG_BITS), .NUM_HASH(NUM_HASH), .IDX_W(IDX_W)) u_rd_sig (
    .clk(clk), .rst_n(rst_n), .clr(tx_clear),
    .ins_en(ins_fire && !ins_is_wr),
    .ins_idx(ins_idx), .tst_idx(prb_idx), .hit(rd_hit)
  );

  sigcd_sig #(.SIG_BITS(SIG_BITS), .NUM_HASH(NUM_HASH), .IDX_W(IDX_W)) u_wr_sig (
    .clk(clk), .rst_n(rst_n), .clr(tx_clear),
    .ins_en(ins_fire && ins_is_wr),
    .ins_idx(ins_idx), .tst_idx(prb_idx), .hit(wr_hit)
  );

  sigcd_classify u_cls (
    .prb_en(prb_en), .prb_is_wr(prb_is_wr),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .kind(kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_pulse <= 1'b0;
      abort_kind  <= 2'b00;
    end else begin
      abort_pulse <= (kind != CONF_NONE);
      abort_kind  <= kind;
    end
  end
endmodule

// File: rtl/sigcd_chk.sv
module sigcd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_begin,
  input logic       tx_clear,
  input logic       prb_valid,
  input logic       prb_is_wr,
  input logic       ins_ready,
  input logic       abort_pulse,
  input logic [1:0] abort_kind
);
  // R7
  pulse_has_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> abort_kind != 2'b00);

  // R7
  quiet_kind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_pulse |-> abort_kind == 2'b00);

  // R9
  pulse_needs_open_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> $past(prb_valid && ins_ready));

  // R4
  read_probe_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && $past(!prb_is_wr)) |-> abort_kind == 2'b10);

  // R10
  clear_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clear && !tx_begin) |=> !ins_ready);
endmodule

bind sig_conflict_det sigcd_chk u_chk (.*);

// File: tb/test_sig_conflict_det.sv
module test_sig_conflict_det;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_begin = 0, tx_clear = 0;
  logic        ins_valid = 0, ins_is_wr = 0, prb_valid = 0, prb_is_wr = 0;
  logic [31:0] ins_addr = '0, prb_addr = '0;
  logic        ins_ready, prb_ready, abort_pulse;
  logic [1:0]  abort_kind;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sig_conflict_det i_sig_conflict_det (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_clear(tx_clear),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr), .ins_is_wr(ins_is_wr),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_addr(prb_addr), .prb_is_wr(prb_is_wr),
    .abort_pulse(abort_pulse), .abort_kind(abort_kind)
  );

  function automatic logic [31:0] ln(input int n);
    return 32'(n) << 6;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge; returns at the next falling edge
  task automatic step(input logic b, input logic c,
                      input logic iv, input logic [31:0] ia, input logic iw,
                      input logic pv, input logic [31:0] pa, input logic pw);
    tx_begin = b; tx_clear = c;
    ins_valid = iv; ins_addr = ia; ins_is_wr = iw;
    prb_valid = pv; prb_addr = pa; prb_is_wr = pw;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0, 0, '0, 0);
  endtask

  task automatic fresh();
    step(1, 1, 0, '0, 0, 0, '0, 0);
  endtask

  task automatic expect_kind(input string req, input logic [1:0] k);
    chk(req, {31'b0, abort_pulse}, {31'b0, k != 2'b00});
    chk(req, {30'b0, abort_kind}, {30'b0, k});
  endtask

  task automatic t_reset();
    chk("R12 ins_ready", {31'b0, ins_ready}, 0);
    chk("R12 prb_ready", {31'b0, prb_ready}, 1);
    expect_kind("R12 no pulse", 2'b00);
  endtask

  task automatic t_read_write();
    fresh();
    chk("R9 open ins_ready", {31'b0, ins_ready}, 1);
    step(0, 0, 1, ln(5), 0, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln(5) + 32'd8, 1);
    expect_kind("R3 R1 write hits read sig", 2'b01);
    idle();
    expect_kind("R7 pulse lasts one cycle", 2'b00);
  endtask

  task automatic t_write_sig();
    fresh();
    step(0, 0, 1, ln(7), 1, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln(7) + 32'd60, 0);
    expect_kind("R4 read hits write sig", 2'b10);
    step(0, 0, 0, '0, 0, 1, ln(7), 1);
    expect_kind("R5 write hits write sig", 2'b11);
    step(0, 0, 1, ln(9), 0, 0, '0, 0);
    step(0, 0, 1, ln(9), 1, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln(9), 1);
    expect_kind("R5 WW over RW priority", 2'b11);
  endtask

  task automatic t_read_read();
    fresh();
    step(0, 0, 1, ln(11), 0, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln(11), 0);
    expect_kind("R6 read on read sig", 2'b00);
  endtask

  task automatic t_hash();
    fresh();
    step(0, 0, 1, ln(1), 0, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln('h100), 1);
    expect_kind("R2 one bit of two set", 2'b00);
    step(0, 0, 1, ln('h100), 0, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln('h103), 1);
    expect_kind("R11 aliasing false hit", 2'b01);
  endtask

  task automatic t_same_cycle();
    fresh();
    step(0, 0, 1, ln(20), 0, 1, ln(20), 1);
    expect_kind("R8 probe sees old sig", 2'b00);
    step(0, 0, 0, '0, 0, 1, ln(20), 1);
    expect_kind("R8 insert landed", 2'b01);
  endtask

  task automatic t_inactive();
    step(0, 1, 0, '0, 0, 0, '0, 0);
    chk("R9 closed ins_ready", {31'b0, ins_ready}, 0);
    step(0, 0, 1, ln(30), 0, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln(30), 1);
    expect_kind("R9 no conflict when closed", 2'b00);
    step(1, 0, 0, '0, 0, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln(30), 1);
    expect_kind("R9 closed insert dropped", 2'b00);
  endtask

  task automatic t_clear();
    fresh();
    step(0, 0, 1, ln(40), 0, 0, '0, 0);
    step(0, 0, 0, '0, 0, 1, ln(40), 1);
    expect_kind("R10 before clear", 2'b01);
    step(1, 1, 1, ln(41), 0, 0, '0, 0);
    chk("R10 reopened", {31'b0, ins_ready}, 1);
    step(0, 0, 0, '0, 0, 1, ln(40), 1);
    expect_kind("R10 signatures emptied", 2'b00);
    step(0, 0, 0, '0, 0, 1, ln(41), 1);
    expect_kind("R10 clear-cycle insert dropped", 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_write();
    t_write_sig();
    t_read_read();
    t_hash();
    t_same_cycle();
    t_inactive();
    t_clear();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule